// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block models a synchronous static RAM whose read and write operations share one pipeline timing. Any mix of reads and writes can be issued on consecutive clock cycles, and the data bus never needs an idle cycle when it changes direction. Every control input, address bit and byte enable is captured on the rising clock edge. The shared data bus appears as three ports: a write-data input, a read-data output and an output-drive flag.

Each operation enters a fixed two-slot pipeline. A read returns its word after the second enabled edge that follows the edge where its address was taken. A write takes its data on that same second edge. A built-in 2-bit counter produces bursts of four words from one loaded address, in either interleaved or linear order. An active-high hold input suspends the whole block, including the pipeline, the burst state and the outputs.

Top module: `nw_sram`

## Requirements
- R1: A read loaded at enabled edge E0 drives `dout` with the addressed word and raises `doe` after the second enabled edge that follows E0.
- R2: While `cke_n` is 1, all other inputs are ignored. `dout`, `doe`, the pipeline and the burst state keep their values, and the timing resumes where it stopped.
- R3: With `adv` = 0 on an enabled edge, `addr` is loaded as the burst base and a new read, write or deselect starts with that exact address.
- R4: With `adv` = 1 on an enabled edge, the 2-bit burst count goes up by one. The operation type set at load time continues, and `bw_n` is sampled again on every beat.
- R5: With `mode_il` = 1 at load, beat k uses the low address bits base[1:0] XOR k. The upper address bits do not change.
- R6: With `mode_il` = 0 at load, beat k uses the low address bits (base[1:0] + k) mod 4. The upper address bits do not change.
- R7: A write stores only the byte lanes whose `bw_n` bit is 0. Lane k is bits [9k+8:9k] of the word. All other lanes keep their contents.
- R8: The block is selected only when `en_a_n` = 0, `en_b` = 1 and `en_c_n` = 0 at load time. Any other combination makes the cycle a deselect, which writes nothing and leaves `doe` at 0.
- R9: Reads and writes can alternate on every cycle with no idle slots. A read issued one cycle after a write to the same address returns the newly written data.
- R10: `doe` is 0 for write and deselect slots. Advance cycles after a deselect load stay deselected.
- R11: During reset `doe` and `dout` are 0 and the burst state is deselected, so advance cycles after reset produce no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke_n | input | 1 | Hold: 1 suspends all registers |
| adv | input | 1 | 1 = advance burst, 0 = load new address |
| we_n | input | 1 | 0 = write, 1 = read (sampled at load) |
| en_a_n | input | 1 | Chip select, active low |
| en_b | input | 1 | Chip select, active high |
| en_c_n | input | 1 | Chip select, active low |
| mode_il | input | 1 | 1 = interleaved, 0 = linear burst order |
| bw_n | input | NB | Per-lane write enables, active low |
| addr | input | AW | Word address |
| din | input | W | Write data, taken two enabled edges after its address |
| dout | output | W | Read data |
| doe | output | 1 | 1 when `dout` carries read data |

## Verification
A wrong slot in the pipeline appears within two enabled cycles. Either `doe` is set at the wrong time, or a write lands in a neighbouring slot and a later read returns the wrong word. A burst counter that steps or wraps incorrectly places beats at the wrong addresses, which shows up when those words are read back in the other burst order. A hold that fails to freeze some register shifts every later result by one slot, so every read after the suspend mismatches.

// File: rtl/nw_sram_pkg.sv
package nw_sram_pkg;
   typedef enum logic [1:0] {
      OP_IDLE = 2'd0,
      OP_RD   = 2'd1,
      OP_WR   = 2'd2
   } op_e;
endpackage

// File: rtl/nw_burst_gen.sv
module nw_burst_gen
   import nw_sram_pkg::*;
#(
   parameter int AW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic          ld,
   input  logic          sel,
   input  logic          we_n,
   input  logic          mode_il,
   input  logic [AW-1:0] addr_in,
   output op_e           iss_op,
   output logic [AW-1:0] iss_addr
);
   op_e           cur_op;
   logic [AW-1:0] base_q;
   logic [1:0]    cnt_q;
   logic          il_q;
   logic [1:0]    cnt_nx;
   logic [1:0]    low_nx;
   op_e           ld_op;

   assign cnt_nx = cnt_q + 2'd1;
   assign low_nx = il_q ? (base_q[1:0] ^ cnt_nx) : (base_q[1:0] + cnt_nx);
   assign ld_op  = !sel ? OP_IDLE : (we_n ? OP_RD : OP_WR);

   always_comb begin
      if (ld) begin
         iss_op   = ld_op;
         iss_addr = addr_in;
      end else begin
         iss_op   = cur_op;
         iss_addr = {base_q[AW-1:2], low_nx};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_op <= OP_IDLE;
         base_q <= '0;
         cnt_q  <= '0;
         il_q   <= 1'b0;
      end else if (step) begin
         if (ld) begin
            cur_op <= ld_op;
            base_q <= addr_in;
            cnt_q  <= '0;
            il_q   <= mode_il;
         end else begin
            cnt_q  <= cnt_nx;
         end
      end
   end
endmodule

// File: rtl/nw_slot_pipe.sv
module nw_slot_pipe #(
   parameter int SW    = 12,
   parameter int DEPTH = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  logic [SW-1:0] slot_in,
   output logic [SW-1:0] slot_out
);
   logic [SW-1:0] chain [DEPTH+1];

   assign chain[0] = slot_in;

   for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      logic [SW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)    q <= '0;
         else if (step) q <= chain[i];
      end
      assign chain[i+1] = q;
   end

   assign slot_out = chain[DEPTH];
endmodule

// File: rtl/nw_mem_core.sv
module nw_mem_core
   import nw_sram_pkg::*;
#(
   parameter int W  = 36,
   parameter int AW = 6,
   parameter int NB = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          step,
   input  op_e           op,
   input  logic [AW-1:0] addr,
   input  logic [NB-1:0] bw_n,
   input  logic [W-1:0]  din,
   output logic [W-1:0]  dout,
   output logic          doe
);
   localparam int LW    = W / NB;
   localparam int WORDS = 1 << AW;

   logic [W-1:0] rd_word;
   logic         wr_go;

   assign wr_go = step && (op == OP_WR);

   for (genvar g = 0; g < NB; g++) begin : g_lane
      logic [LW-1:0] lane_mem [WORDS];
      always_ff @(posedge clk) begin
         if (wr_go && !bw_n[g]) lane_mem[addr] <= din[g*LW +: LW];
      end
      assign rd_word[g*LW +: LW] = lane_mem[addr];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dout <= '0;
         doe  <= 1'b0;
      end else if (step) begin
         doe <= (op == OP_RD);
         if (op == OP_RD) dout <= rd_word;
      end
   end
endmodule

// File: rtl/nw_sram.sv
module nw_sram
   import nw_sram_pkg::*;
#(
   parameter int W   = 36,
   parameter int AW  = 6,
   parameter int NB  = 4,
   parameter int LAT = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cke_n,
   input  logic          adv,
   input  logic          we_n,
   input  logic          en_a_n,
   input  logic          en_b,
   input  logic          en_c_n,
   input  logic          mode_il,
   input  logic [NB-1:0] bw_n,
   input  logic [AW-1:0] addr,
   input  logic [W-1:0]  din,
   output logic [W-1:0]  dout,
   output logic          doe
);
   localparam int SW = 2 + AW + NB;

   if (W % NB != 0) begin : g_bad_lanes
      $error("W must split evenly into NB lanes");
   end
   if (AW < 2) begin : g_bad_aw
      $error("AW must cover the 2-bit burst field");
   end
   if (LAT < 1) begin : g_bad_lat
      $error("LAT must be at least 1");
   end

   logic          step;
   logic          sel;
   op_e           iss_op;
   logic [AW-1:0] iss_addr;
   logic [SW-1:0] slot_in;
   logic [SW-1:0] slot_out;
   op_e           ex_op;
   logic [AW-1:0] ex_addr;
   logic [NB-1:0] ex_bw_n;

   assign step = !cke_n;
   assign sel  = !en_a_n && en_b && !en_c_n;

   nw_burst_gen #(.AW(AW)) u_burst (
      .clk(clk), .rst_n(rst_n), .step(step), .ld(!adv), .sel(sel),
      .we_n(we_n), .mode_il(mode_il), .addr_in(addr),
      .iss_op(iss_op), .iss_addr(iss_addr)
   );

   assign slot_in = {iss_op, iss_addr, bw_n};

   nw_slot_pipe #(.SW(SW), .DEPTH(LAT)) u_pipe (
      .clk(clk), .rst_n(rst_n), .step(step),
      .slot_in(slot_in), .slot_out(slot_out)
   );

   assign ex_op   = op_e'(slot_out[SW-1 -: 2]);
   assign ex_addr = slot_out[NB +: AW];
   assign ex_bw_n = slot_out[NB-1:0];

   nw_mem_core #(.W(W), .AW(AW), .NB(NB)) u_core (
      .clk(clk), .rst_n(rst_n), .step(step), .op(ex_op),
      .addr(ex_addr), .bw_n(ex_bw_n), .din(din),
      .dout(dout), .doe(doe)
   );
endmodule

// File: rtl/nw_sram_chk.sv
module nw_sram_chk #(
   parameter int W = 36
) (
   input logic         clk,
   input logic         rst_n,
   input logic         cke_n,
   input logic         adv,
   input logic         we_n,
   input logic         en_a_n,
   input logic         en_b,
   input logic         en_c_n,
   input logic [W-1:0] dout,
   input logic         doe
);
   logic sel;
   assign sel = !en_a_n && en_b && !en_c_n;

   p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cke_n |=> ($stable(dout) && $stable(doe)));

   p_rd_drive_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && !adv && sel && we_n) ##1 !cke_n ##1 !cke_n |=> doe);

   p_wr_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && !adv && sel && !we_n) ##1 !cke_n ##1 !cke_n |=> !doe);

   p_desel_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke_n && !adv && !sel) ##1 !cke_n ##1 !cke_n |=> !doe);

   p_reset_r11: assert property (@(posedge clk)
      !rst_n |=> (!doe && dout == '0));
endmodule

bind nw_sram nw_sram_chk #(.W(W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cke_n(cke_n), .adv(adv), .we_n(we_n),
   .en_a_n(en_a_n), .en_b(en_b), .en_c_n(en_c_n), .dout(dout), .doe(doe)
);

// File: tb/sim_nw_sram.sv
`timescale 1ns/1ps
module sim_nw_sram;
   localparam int W = 36, AW = 6, NB = 4, NT = 22;

   logic clk = 1'b0, rst_n = 1'b0, cke_n = 1'b0, adv = 1'b0, we_n = 1'b1;
   logic en_a_n = 1'b0, en_b = 1'b1, en_c_n = 1'b0, mode_il = 1'b0;
   logic [NB-1:0] bw_n = '1;
   logic [AW-1:0] addr = '0;
   logic [W-1:0]  din = '0;
   logic [W-1:0]  dout;
   logic          doe;

   always #2.5 clk = ~clk;

   nw_sram #(.W(W), .AW(AW), .NB(NB)) u0 (.*);

   int total = 0, bad = 0, cyc = 0;
   bit done = 0;

   // reference state
   logic [W-1:0]  m_mem [1<<AW];
   logic [1:0]    m_op [2];
   logic [AW-1:0] m_ad [2];
   logic [NB-1:0] m_bw [2];
   logic [1:0]    b_op, b_cnt;
   logic [AW-1:0] b_base;
   logic          b_il, exp_doe;
   logic [W-1:0]  exp_dout;

   // row: {cke_n, adv, we_n, sel[1:0], mode, bw_n[3:0], addr[5:0]}
   // sel 0 = selected, 1/2/3 = one enable inactive
   localparam logic [15:0] TBL [NT] = '{
      {1'b0,1'b0,1'b0,2'd0,1'b0,4'h0,6'd1},
      {1'b0,1'b0,1'b0,2'd0,1'b0,4'h0,6'd2},
      {1'b0,1'b0,1'b1,2'd0,1'b0,4'h0,6'd1},
      {1'b0,1'b0,1'b0,2'd0,1'b0,4'hA,6'd3},
      {1'b0,1'b0,1'b1,2'd0,1'b0,4'h0,6'd2},
      {1'b0,1'b0,1'b1,2'd0,1'b0,4'h0,6'd3},
      {1'b0,1'b0,1'b0,2'd0,1'b0,4'h0,6'd9},
      {1'b0,1'b1,1'b0,2'd0,1'b0,4'h0,6'd0},
      {1'b0,1'b1,1'b0,2'd0,1'b0,4'h0,6'd0},
      {1'b0,1'b1,1'b0,2'd0,1'b0,4'h0,6'd0},
      {1'b0,1'b0,1'b1,2'd0,1'b1,4'h0,6'd9},
      {1'b0,1'b1,1'b1,2'd0,1'b0,4'h0,6'd0},
      {1'b0,1'b1,1'b1,2'd0,1'b0,4'h0,6'd0},
      {1'b1,1'b0,1'b0,2'd0,1'b0,4'h0,6'd1},
      {1'b1,1'b0,1'b0,2'd0,1'b0,4'h0,6'd2},
      {1'b0,1'b1,1'b1,2'd0,1'b0,4'h0,6'd0},
      {1'b0,1'b0,1'b0,2'd1,1'b0,4'h0,6'd1},
      {1'b0,1'b1,1'b0,2'd0,1'b0,4'h0,6'd1},
      {1'b0,1'b0,1'b1,2'd0,1'b0,4'h0,6'd1},
      {1'b0,1'b0,1'b1,2'd0,1'b0,4'h0,6'd8},
      {1'b0,1'b0,1'b1,2'd0,1'b0,4'h0,6'd10},
      {1'b0,1'b0,1'b1,2'd2,1'b0,4'h0,6'd0}
   };

   task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      for (int i = 0; i < 2; i++) begin m_op[i] = 0; m_ad[i] = 0; m_bw[i] = '1; end
      b_op = 0; b_cnt = 0; b_base = 0; b_il = 0; exp_doe = 0; exp_dout = '0;
   endtask

   task automatic step(input logic k, input logic a, input logic w, input logic [1:0] s,
                       input logic m, input logic [NB-1:0] b, input logic [AW-1:0] ad,
                       input string tag);
      logic [1:0] low;
      logic [8:0] c9;
      cke_n = k; adv = a; we_n = w; mode_il = m; bw_n = b; addr = ad;
      en_a_n = (s == 2'd1); en_b = (s != 2'd2); en_c_n = (s == 2'd3);
      c9 = cyc[8:0];
      din = {c9 * 9'd7, ~c9, c9 ^ 9'h155, c9 + 9'd3};
      cyc++;
      @(posedge clk);
      if (!k) begin
         if (m_op[1] == 2'd2) begin
            for (int j = 0; j < NB; j++)
               if (!m_bw[1][j]) m_mem[m_ad[1]][j*9 +: 9] = din[j*9 +: 9];
            exp_doe = 0;
         end else if (m_op[1] == 2'd1) begin
            exp_doe = 1; exp_dout = m_mem[m_ad[1]];
         end else exp_doe = 0;
         m_op[1] = m_op[0]; m_ad[1] = m_ad[0]; m_bw[1] = m_bw[0];
         if (!a) begin
            b_base = ad; b_cnt = 0; b_il = m;
            b_op = (s != 0) ? 2'd0 : (w ? 2'd1 : 2'd2);
            low = ad[1:0];
         end else begin
            b_cnt = b_cnt + 2'd1;
            low = b_il ? (b_base[1:0] ^ b_cnt) : (b_base[1:0] + b_cnt);
         end
         m_op[0] = b_op; m_ad[0] = {b_base[AW-1:2], low}; m_bw[0] = b;
      end
      @(negedge clk);
      chk(doe === exp_doe, {tag, " doe"}, {35'd0, doe}, {35'd0, exp_doe});
      if (exp_doe) chk(dout === exp_dout, {tag, " dout"}, dout, exp_dout);
   endtask

   task automatic flush();
      step(0, 0, 1, 2'd3, 0, '1, 0, "R8 flush");
      step(0, 0, 1, 2'd3, 0, '1, 0, "R8 flush");
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < (1<<AW); i++) m_mem[i] = '0;
      model_reset();
      repeat (3) @(negedge clk);
      chk(doe === 1'b0 && dout === '0, "R11 reset outputs", dout, '0);
      rst_n = 1'b1;
      // R11: advancing straight after reset yields nothing
      step(0, 1, 1, 2'd0, 0, '1, 0, "R11 adv after reset");
      step(0, 1, 1, 2'd0, 0, '1, 0, "R11 adv after reset");
      step(0, 1, 1, 2'd0, 0, '1, 0, "R11 adv after reset");

      // table walk: R1 R3 R4 R5 R6 R7 R9 R10 R2 R8
      for (int i = 0; i < NT; i++) begin
         logic [15:0] r;
         r = TBL[i];
         step(r[15], r[14], r[13], r[12:11], r[10], r[9:6], r[5:0], "R1 R3 R4 R5 R6 table");
      end
      flush();

      // R9: alternating write/read on one address, no gaps
      step(0, 0, 0, 2'd0, 0, 4'h0, 6'd20, "R9 wr");
      step(0, 0, 1, 2'd0, 0, 4'h0, 6'd20, "R9 rd");
      step(0, 0, 0, 2'd0, 0, 4'h0, 6'd21, "R9 wr");
      step(0, 0, 1, 2'd0, 0, 4'h0, 6'd20, "R9 rd");
      step(0, 0, 1, 2'd0, 0, 4'h0, 6'd21, "R9 rd");
      flush();

      // R8: writes with one enable off must not store
      step(0, 0, 0, 2'd1, 0, 4'h0, 6'd1, "R8 desel");
      step(0, 0, 0, 2'd2, 0, 4'h0, 6'd1, "R8 desel");
      step(0, 0, 0, 2'd3, 0, 4'h0, 6'd1, "R8 desel");
      step(0, 0, 1, 2'd0, 0, 4'h0, 6'd1, "R8 readback");
      flush();

      // R7: byte mask 0110 writes lanes 0 and 3 only
      step(0, 0, 0, 2'd0, 0, 4'h6, 6'd2, "R7 mask");
      step(0, 0, 1, 2'd0, 0, 4'h0, 6'd30, "R7 idle");
      step(0, 0, 1, 2'd0, 0, 4'h0, 6'd2, "R7 readback");
      flush();

      // R6: linear wrap from base 3 -> 3,0,1,2 ; read back interleaved 3,2,1,0
      step(0, 0, 0, 2'd0, 0, 4'h0, 6'd3, "R6 lin wr");
      step(0, 1, 0, 2'd0, 0, 4'h0, 6'd0, "R6 lin wr");
      step(0, 1, 0, 2'd0, 0, 4'h3, 6'd0, "R4 bw per beat");
      step(0, 1, 0, 2'd0, 0, 4'h0, 6'd0, "R6 lin wr");
      step(0, 0, 1, 2'd0, 1, 4'h0, 6'd3, "R5 il rd");
      step(0, 1, 1, 2'd0, 0, 4'h0, 6'd0, "R5 il rd");
      step(0, 1, 1, 2'd0, 0, 4'h0, 6'd0, "R5 il rd");
      step(0, 1, 1, 2'd0, 0, 4'h0, 6'd0, "R5 il rd");
      flush();

      // R2: suspend with a read in flight, outputs frozen
      step(0, 0, 1, 2'd0, 0, 4'h0, 6'd20, "R2 rd");
      step(0, 0, 1, 2'd0, 0, 4'h0, 6'd21, "R2 rd");
      step(0, 0, 1, 2'd0, 0, 4'h0, 6'd3, "R2 rd");
      begin
         logic [W-1:0] hold_d;
         logic         hold_e;
         hold_d = dout; hold_e = doe;
         step(1, 0, 0, 2'd0, 0, 4'h0, 6'd1, "R2 hold");
         step(1, 1, 0, 2'd1, 1, 4'h0, 6'd2, "R2 hold");
         chk(dout === hold_d && doe === hold_e, "R2 frozen", dout, hold_d);
      end
      step(0, 0, 1, 2'd0, 0, 4'h0, 6'd9, "R2 resume");
      flush();

      // R10: deselect ends burst; advances stay quiet
      step(0, 0, 1, 2'd0, 0, 4'h0, 6'd8, "R10 rd");
      step(0, 0, 1, 2'd3, 0, 4'h0, 6'd8, "R10 desel");
      step(0, 1, 0, 2'd0, 0, 4'h0, 6'd0, "R10 adv");
      step(0, 1, 1, 2'd0, 0, 4'h0, 6'd0, "R10 adv");
      step(0, 1, 1, 2'd0, 0, 4'h0, 6'd0, "R10 adv");

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule